// File: doc/BRIEF.md
# Cascaded Parallel-Input Shift-Chain Reader

This block is a synchronous master that reads a daisy chain of 8-bit parallel-in, serial-out shift registers. Each stage's serial output feeds the next stage's serial input. The output of the stage nearest the controller arrives on a single data input. When a start request arrives, the block runs a fixed strobe sequence on two dedicated lines, none of which is a chip select. It first raises a capture strobe, which freezes the parallel inputs of the chain. It then drops an active-low load line, which copies the frozen values into the shift stages. After that it produces mode-0 shift clocks: the clock idles low and data is sampled on the rising edge.

With the default of ten stages, one transaction collects 80 bits, most significant bit first. The first bit out of the chain becomes bit 79 of the result word. Each shift edge moves every bit one place toward the output and discards the bit that was presented there, so a read empties the chain. At the end the block updates the result word and pulses done for one cycle.

The shift clock runs at the system clock divided by an even divisor. The divisor is taken from an input at the moment a request is accepted.

Top module: `chain_reader`

## Requirements
- R1: After reset, cap_o is 0, load_n_o is 1, sclk_o is 0, done_o is 0 and result_o is all zeros.
- R2: A start_i that is high at a clock edge while no transaction is running is accepted at that edge. cap_o rises at the same edge and stays high for exactly one shift period P.
- R3: cap_o is followed by exactly one period P with both strobes inactive. load_n_o then goes low for exactly P cycles. cap_o and a low load_n_o never overlap.
- R4: The first rising edge of sclk_o comes exactly P + P/2 cycles after load_n_o returns high. sclk_o idles low and is high for P/2 cycles per bit. Consecutive rising edges are P cycles apart. sclk_o is never high while a strobe is active.
- R5: Each transaction produces exactly NUM_STAGES*STAGE_W = 80 rising edges of sclk_o.
- R6: sdi_i is sampled at the clock edge where sclk_o rises. The first bit sampled lands in result_o[79] and the last in result_o[0], so stage k counted from the controller appears in bits [79-8k:72-8k].
- R7: done_o is a one-cycle pulse. It coincides with the first cycle in which result_o holds the new word, and it follows the last falling edge of sclk_o. result_o changes only together with done_o and holds its value until the next done_o.
- R8: start_i pulses that arrive while a transaction is running are ignored: they cause no extra capture strobe, no extra shift edges and no extra done_o.
- R9: P is 2*floor(div_i/2), and div_i values 0 and 1 behave as 2. div_i is sampled only when a start is accepted, so later changes do not affect the running transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to read the chain |
| div_i | input | DIV_W (8) | Shift clock divisor in system clock cycles |
| sdi_i | input | 1 | Serial data from the last chain stage |
| cap_o | output | 1 | Capture strobe, active high |
| load_n_o | output | 1 | Parallel load, active low |
| sclk_o | output | 1 | Shift clock, mode 0 |
| result_o | output | NUM_STAGES*STAGE_W (80) | Assembled chain contents, first bit in MSB |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench models the chain itself: a capture register that is latched on the strobe's rising edge, and an 80-bit shifter that is loaded while the load line is low and shifted on each rising clock edge. A design that loaded before capturing, or that sampled after the chain had already shifted, therefore returns a word that is stale or off by one bit. The bench sweeps several divisors, including odd values and zero, and measures every strobe width, gap and clock half period in cycles. This exposes divisor rounding errors and a first edge that comes a half period early. Separate transactions change the divisor mid-read and pulse start mid-read; a design that re-sampled the divisor or restarted on the extra pulse would show wrong periods, extra strobes or a second done pulse.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CAP   = 3'd1,
    ST_GAP1  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_GAP2  = 3'd4,
    ST_SHIFT = 3'd5
  } rd_state_t;

  // Half of the shift period in system cycles, never below one.
  function automatic logic [15:0] half_of(input logic [15:0] div);
    logic [15:0] h;
    h = div >> 1;
    if (h == 16'd0) h = 16'd1;
    return h;
  endfunction

endpackage

// File: rtl/chain_rd_tick.sv
module chain_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == half_i - 1'b1);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/chain_rd_seq.sv
module chain_rd_seq
  import chain_rd_pkg::*;
#(
  parameter int BITS  = 80,
  parameter int CNT_W = $clog2(BITS)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick_i,
  output logic run_o,
  output logic cap_o,
  output logic load_n_o,
  output logic sclk_o,
  output logic sample_o,
  output logic fin_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

  rd_state_t        state_q;
  logic             half_q;
  logic [CNT_W-1:0] bit_q;
  logic             period_end;

  assign period_end = tick_i && half_q;
  assign sample_o   = (state_q == ST_SHIFT) && tick_i && !sclk_o;
  assign fin_o      = (state_q == ST_SHIFT) && tick_i && sclk_o && (bit_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      half_q   <= 1'b0;
      bit_q    <= '0;
      run_o    <= 1'b0;
      cap_o    <= 1'b0;
      load_n_o <= 1'b1;
      sclk_o   <= 1'b0;
    end else begin
      if (tick_i && state_q != ST_SHIFT) begin
        half_q <= !half_q;
      end
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CAP;
            run_o   <= 1'b1;
            cap_o   <= 1'b1;
            half_q  <= 1'b0;
            bit_q   <= '0;
          end
        end
        ST_CAP: begin
          if (period_end) begin
            cap_o   <= 1'b0;
            state_q <= ST_GAP1;
          end
        end
        ST_GAP1: begin
          if (period_end) begin
            load_n_o <= 1'b0;
            state_q  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (period_end) begin
            load_n_o <= 1'b1;
            state_q  <= ST_GAP2;
          end
        end
        ST_GAP2: begin
          if (period_end) begin
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            if (!sclk_o) begin
              sclk_o <= 1'b1;
            end else begin
              sclk_o <= 1'b0;
              if (bit_q == LAST_BIT) begin
                state_q <= ST_IDLE;
                run_o   <= 1'b0;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chain_rd_shreg.sv
module chain_rd_shreg #(
  parameter int NUM_STAGES = 10,
  parameter int STAGE_W    = 8,
  parameter int RES_W      = NUM_STAGES * STAGE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             sdi_i,
  output logic [RES_W-1:0] data_o
);

  // One register per stage; the serial stream enters at the low stage
  // and each stage's top bit carries into the stage above it.
  logic [NUM_STAGES-1:0][STAGE_W-1:0] stg_q;
  logic [NUM_STAGES:0]                carry;

  assign carry[0] = sdi_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    assign carry[k+1] = stg_q[k][STAGE_W-1];
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        stg_q[k] <= '0;
      end else if (shift_i) begin
        stg_q[k] <= {stg_q[k][STAGE_W-2:0], carry[k]};
      end
    end
  end

  assign data_o = stg_q;

endmodule

// File: rtl/chain_reader.sv
module chain_reader
  import chain_rd_pkg::*;
#(
  parameter int NUM_STAGES = 10,
  parameter int STAGE_W    = 8,
  parameter int DIV_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic [DIV_W-1:0]              div_i,
  input  logic                          sdi_i,
  output logic                          cap_o,
  output logic                          load_n_o,
  output logic                          sclk_o,
  output logic [NUM_STAGES*STAGE_W-1:0] result_o,
  output logic                          done_o
);

  localparam int RES_W = NUM_STAGES * STAGE_W;

  logic             run;
  logic             tick;
  logic             sample;
  logic             fin;
  logic             accept;
  logic [DIV_W-1:0] half_q;
  logic [RES_W-1:0] assembled;

  assign accept = start_i && !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= DIV_W'(1);
    end else if (accept) begin
      half_q <= DIV_W'(half_of(16'(div_i)));
    end
  end

  chain_rd_tick #(.DIV_W(DIV_W)) tick_i (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .half_i (half_q),
    .tick_o (tick)
  );

  chain_rd_seq #(.BITS(RES_W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .tick_i   (tick),
    .run_o    (run),
    .cap_o    (cap_o),
    .load_n_o (load_n_o),
    .sclk_o   (sclk_o),
    .sample_o (sample),
    .fin_o    (fin)
  );

  chain_rd_shreg #(.NUM_STAGES(NUM_STAGES), .STAGE_W(STAGE_W)) shreg_i (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (accept),
    .shift_i (sample),
    .sdi_i   (sdi_i),
    .data_o  (assembled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        result_o <= assembled;
      end
    end
  end

endmodule

// File: rtl/chain_rd_chk.sv
module chain_rd_chk #(
  parameter int RES_W = 80
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_o,
  input logic             load_n_o,
  input logic             sclk_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);

  logic [15:0] rises_q;

  always_ff @(posedge clk) begin
    if (rst || done_o) begin
      rises_q <= '0;
    end else if (sclk_o && !$past(sclk_o)) begin
      rises_q <= rises_q + 1'b1;
    end
  end

  assert_no_strobe_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(cap_o && !load_n_o));

  assert_sclk_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> (load_n_o && !cap_o));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (!$changed(result_o) || done_o));

  assert_done_clock_low_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !sclk_o);

  assert_edge_count_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rises_q == 16'(RES_W)));

endmodule

bind chain_reader chain_rd_chk #(.RES_W(NUM_STAGES*STAGE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cap_o    (cap_o),
  .load_n_o (load_n_o),
  .sclk_o   (sclk_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/chain_reader_tb_top.sv
`timescale 1ns/1ps
module chain_reader_tb_top;

  localparam int NS    = 10;
  localparam int SW    = 8;
  localparam int RW    = NS * SW;
  localparam int DIV_W = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [DIV_W-1:0] div_i = 8'd2;
  logic          sdi_i;
  logic          cap_o, load_n_o, sclk_o, done_o;
  logic [RW-1:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = !clk;

  chain_reader #(.NUM_STAGES(NS), .STAGE_W(SW), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .div_i(div_i), .sdi_i(sdi_i),
    .cap_o(cap_o), .load_n_o(load_n_o), .sclk_o(sclk_o),
    .result_o(result_o), .done_o(done_o)
  );

  // Chain model: capture register, then shift stages loaded while load is low.
  logic [RW-1:0] par_in = '0;
  logic [RW-1:0] held   = '0;
  logic [RW-1:0] chain  = '0;
  assign sdi_i = chain[RW-1];

  always @(posedge cap_o) held <= par_in;
  always @(negedge load_n_o or posedge sclk_o) begin
    if (!load_n_o) chain <= held;
    else           chain <= {chain[RW-2:0], 1'b0};
  end

  // Edge monitor, sampled away from the active edge.
  int cyc = 0;
  int exp_p = 2;
  int t_cap_r, t_cap_f, t_ld_f, t_ld_r, t_first, t_last;
  int n_rise, n_cap, n_done, bad_per, bad_hi;
  logic p_cap = 1'b0, p_ld = 1'b1, p_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (cap_o && !p_cap) begin t_cap_r = cyc; n_cap++; end
    if (!cap_o && p_cap) t_cap_f = cyc;
    if (!load_n_o && p_ld) t_ld_f = cyc;
    if (load_n_o && !p_ld) t_ld_r = cyc;
    if (sclk_o && !p_sclk) begin
      if (n_rise == 0) t_first = cyc;
      else if (cyc - t_last != exp_p) bad_per++;
      t_last = cyc;
      n_rise++;
    end
    if (!sclk_o && p_sclk && (cyc - t_last != exp_p / 2)) bad_hi++;
    if (done_o) n_done++;
    p_cap = cap_o; p_ld = load_n_o; p_sclk = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_period(input int d);
    int h;
    h = d / 2;
    if (h < 1) h = 1;
    return 2 * h;
  endfunction

  function automatic logic [RW-1:0] pattern(input int trial);
    logic [RW-1:0] v;
    for (int i = 0; i < NS; i++) begin
      case (trial)
        0: v[RW-1-SW*i -: SW] = 8'hFF;
        1: v[RW-1-SW*i -: SW] = 8'h00;
        2: v[RW-1-SW*i -: SW] = (i % 2 == 0) ? 8'hA5 : 8'h5A;
        default: v[RW-1-SW*i -: SW] = 8'((trial * 37 + i * 91 + 5) ^ (i << 4));
      endcase
    end
    return v;
  endfunction

  // mode 0: plain, 1: change divisor mid-read, 2: extra start mid-read
  task automatic run_txn(input int trial, input int d, input int mode);
    int c0;
    int p;
    int done_before;
    logic [RW-1:0] expv;
    p = eff_period(d);
    expv = pattern(trial);
    par_in = expv;
    div_i = DIV_W'(d);
    exp_p = p;
    n_rise = 0; n_cap = 0; bad_per = 0; bad_hi = 0;
    done_before = n_done;
    @(negedge clk); #1;
    c0 = cyc;
    start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    chk(t_cap_r == c0 + 1, "R2 capture rises at accepting edge", t_cap_r - c0, 1);
    // change par_in after capture: must not reach result
    par_in = ~expv;
    if (mode == 1) div_i = DIV_W'(d + 6);
    if (mode == 2) begin
      repeat (5 * p) @(negedge clk);
      #1 start_i = 1'b1;
      @(negedge clk); #1 start_i = 1'b0;
    end
    while (!done_o) begin @(negedge clk); #1; end
    n_tests++;
    if (result_o !== expv) begin
      n_fail++;
      $display("FAIL R6 result word: actual %h expected %h", result_o, expv);
    end
    chk(t_cap_f - t_cap_r == p, "R2 capture width", t_cap_f - t_cap_r, p);
    chk(t_ld_f - t_cap_f == p, "R3 gap before load", t_ld_f - t_cap_f, p);
    chk(t_ld_r - t_ld_f == p, "R3 load width", t_ld_r - t_ld_f, p);
    chk(t_first - t_ld_r == p + p / 2, "R4 first rise delay", t_first - t_ld_r, p + p / 2);
    chk(bad_per == 0, "R4 rise spacing (R9 period)", bad_per, 0);
    chk(bad_hi == 0, "R4 high half width", bad_hi, 0);
    chk(n_rise == RW, "R5 rise count", n_rise, RW);
    chk(t_last < cyc, "R7 done after last fall", cyc - t_last, 1);
    @(negedge clk); #1;
    chk(done_o == 1'b0, "R7 done single cycle", int'(done_o), 0);
    repeat (12) @(negedge clk);
    #1;
    chk(n_done - done_before == 1, "R8 single done per read", n_done - done_before, 1);
    chk(n_cap == 1, "R8 single capture strobe", n_cap, 1);
    chk(n_rise == RW, "R8 no extra shift edges", n_rise, RW);
    chk(result_o === expv, "R7 result holds", 0, 0);
    div_i = 8'd2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(cap_o == 1'b0, "R1 cap idle", int'(cap_o), 0);
    chk(load_n_o == 1'b1, "R1 load idle", int'(load_n_o), 1);
    chk(sclk_o == 1'b0, "R1 sclk idle", int'(sclk_o), 0);
    chk(done_o == 1'b0, "R1 done idle", int'(done_o), 0);
    chk(result_o == '0, "R1 result zero", 0, 0);
    run_txn(0, 2, 0);
    run_txn(1, 4, 0);
    run_txn(2, 3, 0);   // R9 odd rounds down
    run_txn(3, 0, 0);   // R9 zero acts as two
    run_txn(4, 1, 0);
    run_txn(5, 6, 1);   // R9 divisor latched
    run_txn(6, 8, 2);   // R8 start while busy
    run_txn(7, 2, 2);
    run_txn(8, 10, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule